// File: doc/BRIEF.md
# Half-Stacked Register File with Two-Pass ALU

This block holds 32 architectural registers, each 128 bits wide, in one memory that is only 64 bits wide and twice as deep. Every register is split into a low and a high 64-bit half. All the low halves fill the first 32 rows and all the high halves fill the next 32 rows. A 64-bit arithmetic unit works on one half at a time.

A 128-bit operation makes two passes through the unit. The low halves go first. The carry or borrow out of that pass is stored in a register and fed in as the carry-in of the high pass, so the result is the exact 128-bit value. Each pass writes its half of the destination back as soon as it is computed. A 64-bit operation makes only the low pass and leaves the destination's high half alone.

A caller offers one operation at a time: opcode, width flag, destination and two sources. It watches `busy` and `done`. A separate debug port reads any single row of the memory.

Top module: `hsrf_core`

## Requirements
- R1: Register n stores its low half at memory row n and its high half at row 32+n. The debug port returns row {dbg_hi, dbg_reg} on `dbg_data` one clock edge after the address is presented.
- R2: Before any write, memory row k (k = 0..63) holds k × 0x0101010101010101, truncated to 64 bits. A reset does not change the memory contents.
- R3: `req_op` selects the function: 0 = add, 1 = subtract (Rs1 − Rs2), 2 = bitwise AND, 3 = bitwise XOR. With `req_wide`=1 the full 128-bit result, modulo 2^128, is written to Rd.
- R4: For a 128-bit add or subtract, the carry (or borrow) out of the low-half pass enters the high-half pass. The result therefore matches a true 128-bit add or subtract.
- R5: With `req_wide`=0, only the low 64 bits of Rd receive the 64-bit result. Rd's high half keeps its value, and the carry out is discarded.
- R6: A request is taken at a rising edge where `req_valid`=1 and `busy`=0. `busy` is 1 from the next cycle on. `done` rises for exactly one cycle, and `busy` falls with it, after the 2nd edge following acceptance for a 64-bit operation, or after the 4th edge for a 128-bit operation.
- R7: A request offered while `busy`=1 is dropped. It changes no register and produces no `done`.
- R8: When Rd equals Rs1 or Rs2, the high pass still reads the original high halves of the sources.
- R9: Register 0 is an ordinary register. A 128-bit write updates both of its halves, and later reads return what was written.
- R10: While `rst` is high, `busy` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Operation request |
| req_op | input | 2 | Function select (0 add, 1 sub, 2 and, 3 xor) |
| req_wide | input | 1 | 1 = 128-bit operation, 0 = 64-bit |
| req_rd | input | 5 | Destination register |
| req_rs1 | input | 5 | First source register |
| req_rs2 | input | 5 | Second source register |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| dbg_reg | input | 5 | Debug read register index |
| dbg_hi | input | 1 | Debug read half select (1 = high) |
| dbg_data | output | 64 | Debug read data, registered |

## Verification
Results fall due at fixed edges after the accepting edge:
- A 64-bit operation raises `done` after 2 edges.
- A 128-bit operation raises `done` after 4 edges.
- A debug read returns its row 1 edge after the address is presented.

The driver stamps each expected item with its due cycle. The monitor takes `done` at falling edges and compares the current cycle with that stamp. It then reads both halves of Rd through the debug port, one edge each, before the next operation can write. A final sweep of all rows confirms that the untouched registers, including the target of a dropped request, are intact, both before and after a reset.

// File: rtl/hsrf_pkg.sv
package hsrf_pkg;
  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_SUB = 2'd1,
    OP_AND = 2'd2,
    OP_XOR = 2'd3
  } alu_op_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_RD_LO = 3'd1,
    ST_EX_LO = 3'd2,
    ST_RD_HI = 3'd3,
    ST_EX_HI = 3'd4
  } seq_state_e;
endpackage

// File: rtl/hsrf_rowmem.sv
// Deep, narrow row store. One copy per read port, all written together,
// so each copy maps to a simple dual-port block RAM.
module hsrf_rowmem #(
  parameter int ROWS = 64,
  parameter int W    = 64,
  parameter int NRD  = 3,
  localparam int AW  = $clog2(ROWS)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_row,
  input  logic [W-1:0]      wr_data,
  input  logic [NRD*AW-1:0] rd_row,
  output logic [NRD*W-1:0]  rd_data
);
  localparam logic [W-1:0] FILL = {(W/8){8'h01}};

  for (genvar p = 0; p < NRD; p++) begin : g_copy
    logic [W-1:0] store [ROWS];
    logic [W-1:0] q;

    // power-up contents: row k = k * FILL
    initial begin
      for (int k = 0; k < ROWS; k++) store[k] = W'(k) * FILL;
    end

    always_ff @(posedge clk) begin
      if (wr_en) store[wr_row] <= wr_data;
      q <= store[rd_row[p*AW +: AW]];
    end

    assign rd_data[p*W +: W] = q;
  end
endmodule

// File: rtl/hsrf_alu.sv
module hsrf_alu
  import hsrf_pkg::*;
#(
  parameter int W = 64
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] y,
  output logic         cout
);
  logic [W:0]   sum;
  logic [W-1:0] bx;

  always_comb begin
    bx   = (op == OP_SUB) ? ~b : b;
    sum  = {1'b0, a} + {1'b0, bx} + {{W{1'b0}}, cin};
    cout = 1'b0;
    unique case (op)
      OP_ADD, OP_SUB: begin
        y    = sum[W-1:0];
        cout = sum[W];
      end
      OP_AND:  y = a & b;
      default: y = a ^ b;
    endcase
  end
endmodule

// File: rtl/hsrf_seq.sv
// Pass sequencer: read-low, exec/write-low, [read-high, exec/write-high].
module hsrf_seq
  import hsrf_pkg::*;
#(
  parameter int RW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  alu_op_e       req_op,
  input  logic          req_wide,
  input  logic [RW-1:0] req_rd,
  input  logic [RW-1:0] req_rs1,
  input  logic [RW-1:0] req_rs2,
  output logic          busy,
  output logic          done,
  output logic [RW:0]   rd1_row,
  output logic [RW:0]   rd2_row,
  output logic          wr_en,
  output logic [RW:0]   wr_row,
  output alu_op_e       alu_op,
  output logic          alu_cin,
  input  logic          alu_cout
);
  seq_state_e    st, st_n;
  alu_op_e       op_q;
  logic          wide_q, carry_q, busy_q, done_q, accept, hi_pass;
  logic [RW-1:0] rd_q, rs1_q, rs2_q;

  assign accept = req_valid && (st == ST_IDLE);

  always_comb begin
    st_n = st;
    unique case (st)
      ST_IDLE:  if (req_valid) st_n = ST_RD_LO;
      ST_RD_LO: st_n = ST_EX_LO;
      ST_EX_LO: st_n = wide_q ? ST_RD_HI : ST_IDLE;
      ST_RD_HI: st_n = ST_EX_HI;
      ST_EX_HI: st_n = ST_IDLE;
      default:  st_n = ST_IDLE;
    endcase
  end

  assign hi_pass = (st == ST_RD_HI) || (st == ST_EX_HI);
  assign rd1_row = {hi_pass, rs1_q};
  assign rd2_row = {hi_pass, rs2_q};
  assign wr_en   = (st == ST_EX_LO) || (st == ST_EX_HI);
  assign wr_row  = {st == ST_EX_HI, rd_q};
  assign alu_op  = op_q;
  assign alu_cin = (st == ST_EX_HI) ? carry_q : (op_q == OP_SUB);

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      carry_q <= 1'b0;
      op_q    <= OP_ADD;
      wide_q  <= 1'b0;
      rd_q    <= '0;
      rs1_q   <= '0;
      rs2_q   <= '0;
    end else begin
      st     <= st_n;
      busy_q <= (st_n != ST_IDLE);
      done_q <= ((st == ST_EX_LO) && !wide_q) || (st == ST_EX_HI);
      if (st == ST_EX_LO) carry_q <= alu_cout;
      if (accept) begin
        op_q   <= req_op;
        wide_q <= req_wide;
        rd_q   <= req_rd;
        rs1_q  <= req_rs1;
        rs2_q  <= req_rs2;
      end
    end
  end

  assign busy = busy_q;
  assign done = done_q;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);                                                   // R6
  AST_BUSY_ENDS_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);                                             // R6
  AST_HI_WRITE_ONLY_WIDE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_row[RW]) |-> wide_q);                                 // R5
  AST_HI_FOLLOWS_LO: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_row[RW]) |-> ($past(wr_en, 2) && !$past(wr_row[RW], 2)
                               && !$past(wr_en)));                     // R4
  AST_BUSY_REQ_DROPPED: assert property (@(posedge clk) disable iff (rst)
    (busy && req_valid) |=> ($stable(rd_q) && $stable(op_q) && $stable(rs1_q))); // R7
endmodule

// File: rtl/hsrf_core.sv
module hsrf_core
  import hsrf_pkg::*;
#(
  parameter int NREGS  = 32,
  parameter int HALF_W = 64,
  localparam int RW    = $clog2(NREGS),
  localparam int ROWS  = 2 * NREGS,
  localparam int NRD   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic              req_wide,
  input  logic [RW-1:0]     req_rd,
  input  logic [RW-1:0]     req_rs1,
  input  logic [RW-1:0]     req_rs2,
  output logic              busy,
  output logic              done,
  input  logic [RW-1:0]     dbg_reg,
  input  logic              dbg_hi,
  output logic [HALF_W-1:0] dbg_data
);
  logic [RW:0]         rd1_row, rd2_row, wr_row;
  logic                wr_en, alu_cin, alu_cout;
  alu_op_e             alu_op;
  logic [HALF_W-1:0]   alu_y;
  logic [NRD*HALF_W-1:0] rd_data;

  hsrf_seq #(.RW(RW)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .req_valid(req_valid),
    .req_op   (alu_op_e'(req_op)),
    .req_wide (req_wide),
    .req_rd   (req_rd),
    .req_rs1  (req_rs1),
    .req_rs2  (req_rs2),
    .busy     (busy),
    .done     (done),
    .rd1_row  (rd1_row),
    .rd2_row  (rd2_row),
    .wr_en    (wr_en),
    .wr_row   (wr_row),
    .alu_op   (alu_op),
    .alu_cin  (alu_cin),
    .alu_cout (alu_cout)
  );

  hsrf_rowmem #(.ROWS(ROWS), .W(HALF_W), .NRD(NRD)) u_mem (
    .clk    (clk),
    .wr_en  (wr_en),
    .wr_row (wr_row),
    .wr_data(alu_y),
    .rd_row ({dbg_hi, dbg_reg, rd2_row, rd1_row}),
    .rd_data(rd_data)
  );

  hsrf_alu #(.W(HALF_W)) u_alu (
    .op  (alu_op),
    .a   (rd_data[0 +: HALF_W]),
    .b   (rd_data[HALF_W +: HALF_W]),
    .cin (alu_cin),
    .y   (alu_y),
    .cout(alu_cout)
  );

  assign dbg_data = rd_data[2*HALF_W +: HALF_W];
endmodule

// File: tb/hsrf_core_tb.sv
module hsrf_core_tb;
  import hsrf_pkg::*;
  localparam int CLK_NS = 10;
  localparam int NREGS  = 32;

  logic        clk = 1'b0, rst = 1'b1;
  logic        req_valid = 1'b0, req_wide = 1'b0, dbg_hi = 1'b0;
  logic [1:0]  req_op = 2'd0;
  logic [4:0]  req_rd = '0, req_rs1 = '0, req_rs2 = '0, dbg_reg = '0;
  logic        busy, done;
  logic [63:0] dbg_data;

  hsrf_core u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_wide(req_wide), .req_rd(req_rd), .req_rs1(req_rs1), .req_rs2(req_rs2),
    .busy(busy), .done(done), .dbg_reg(dbg_reg), .dbg_hi(dbg_hi),
    .dbg_data(dbg_data)
  );

  always #(CLK_NS/2) clk = ~clk;

  int unsigned cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, errors = 0;
  logic [127:0] shadow [NREGS];

  typedef struct {
    int unsigned  due;
    logic [4:0]   rd;
    logic [127:0] val;
  } exp_t;
  exp_t  sbq[$];
  string tagq[$];

  function automatic logic [63:0] fill(int k);
    return 64'(k) * 64'h0101_0101_0101_0101;
  endfunction

  task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic dbg_read(int r, logic hi, output logic [63:0] v);
    dbg_reg = 5'(r);
    dbg_hi  = hi;
    @(negedge clk);
    v = dbg_data;
  endtask

  task automatic issue(alu_op_e op, logic wide, int rd, int rs1, int rs2, string tag);
    logic [127:0] a, b, r;
    logic [63:0]  lo;
    exp_t e;
    while (busy) @(negedge clk);
    a = shadow[rs1];
    b = shadow[rs2];
    if (wide) begin
      case (op)
        OP_ADD:  r = a + b;
        OP_SUB:  r = a - b;
        OP_AND:  r = a & b;
        default: r = a ^ b;
      endcase
    end else begin
      case (op)
        OP_ADD:  lo = a[63:0] + b[63:0];
        OP_SUB:  lo = a[63:0] - b[63:0];
        OP_AND:  lo = a[63:0] & b[63:0];
        default: lo = a[63:0] ^ b[63:0];
      endcase
      r = {shadow[rd][127:64], lo};
    end
    shadow[rd] = r;
    e.due = cyc + 1 + (wide ? 4 : 2);
    e.rd  = 5'(rd);
    e.val = r;
    sbq.push_back(e);
    tagq.push_back(tag);
    req_valid = 1'b1; req_op = op; req_wide = wide;
    req_rd = 5'(rd); req_rs1 = 5'(rs1); req_rs2 = 5'(rs2);
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " R6 busy after accept"}, {127'd0, busy}, 128'd1);
  endtask

  // monitor: pops the scoreboard on every done pulse
  initial begin
    forever begin
      @(negedge clk);
      if (done) begin
        exp_t e;
        string t;
        logic [63:0] lo, hi;
        if (sbq.size() == 0) begin
          checks++; errors++;
          $display("FAIL R7 unexpected done actual 1 expected 0");
        end else begin
          e = sbq.pop_front();
          t = tagq.pop_front();
          chk({t, " R6 latency"}, 128'(cyc), 128'(e.due));
          dbg_read(int'(e.rd), 1'b0, lo);
          chk({t, " R6 done pulse"}, {127'd0, done}, 128'd0);
          dbg_read(int'(e.rd), 1'b1, hi);
          chk(t, {hi, lo}, e.val);
        end
      end
    end
  end

  initial begin
    #(CLK_NS * 200000);
    checks++; errors++;
    $display("FAIL R6 watchdog actual hung expected finished");
    finish_run();
  end

  task automatic sweep(string tag);
    logic [63:0] lo, hi;
    for (int r = 0; r < NREGS; r++) begin
      dbg_read(r, 1'b0, lo);
      dbg_read(r, 1'b1, hi);
      chk(tag, {hi, lo}, shadow[r]);
    end
  endtask

  initial begin
    logic [63:0] v;
    for (int n = 0; n < NREGS; n++) shadow[n] = {fill(n + 32), fill(n)};
    repeat (3) @(negedge clk);
    chk("R10 busy in reset", {127'd0, busy}, 128'd0);
    chk("R10 done in reset", {127'd0, done}, 128'd0);
    rst = 1'b0;
    @(negedge clk);
    // R2 / R1: power-up rows through the debug port
    dbg_read(3, 1'b0, v);  chk("R2 row 3", 128'(v), 128'(fill(3)));
    dbg_read(3, 1'b1, v);  chk("R1 row 35", 128'(v), 128'(fill(35)));
    dbg_read(31, 1'b1, v); chk("R1 row 63", 128'(v), 128'(fill(63)));

    issue(OP_ADD, 1'b1, 5, 1, 2, "R3 wide add");
    issue(OP_SUB, 1'b1, 6, 0, 1, "R4 wide borrow");
    issue(OP_ADD, 1'b1, 7, 6, 1, "R4 wide carry");
    issue(OP_ADD, 1'b0, 8, 6, 6, "R5 narrow carry drop");
    issue(OP_SUB, 1'b0, 9, 0, 2, "R5 narrow sub");
    issue(OP_AND, 1'b1, 10, 6, 13, "R3 wide and");
    issue(OP_XOR, 1'b1, 11, 6, 12, "R3 wide xor");
    issue(OP_ADD, 1'b1, 3, 3, 3, "R8 alias both");
    issue(OP_SUB, 1'b1, 4, 9, 4, "R8 alias rs2");
    issue(OP_XOR, 1'b1, 12, 12, 30, "R8 alias rs1");
    issue(OP_XOR, 1'b1, 0, 10, 11, "R9 reg0 write");
    issue(OP_ADD, 1'b1, 14, 0, 0, "R9 reg0 read");
    issue(OP_ADD, 1'b1, 15, 1, 2, "R7 host op");
    // R7: offer a request while busy; it must be dropped
    req_valid = 1'b1; req_op = OP_XOR; req_wide = 1'b1;
    req_rd = 5'd20; req_rs1 = 5'd6; req_rs2 = 5'd7;
    @(negedge clk);
    req_valid = 1'b0;
    issue(OP_AND, 1'b0, 16, 6, 0, "R5 narrow and");
    issue(OP_SUB, 1'b0, 17, 17, 17, "R8 narrow alias");

    repeat (12) @(negedge clk);
    chk("R7 scoreboard drained", 128'(sbq.size()), 128'd0);
    sweep("R1 R7 sweep");

    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 busy reset again", {127'd0, busy}, 128'd0);
    rst = 1'b0;
    @(negedge clk);
    sweep("R2 contents kept over reset");
    finish_run();
  end
endmodule